// File: doc/BRIEF.md
# Interrupt-Aware Microcode Sequencer

This block is the control unit of a multicycle 32-bit processor. It is built from ROMs. Each cycle it presents a 28-bit control word taken from a main microcode ROM, which is addressed by the current microstate. Each bit of the word drives one strobe or select line in the datapath. The block chooses the next microstate from one of four sources: the next-state field carried in the word itself, an opcode dispatch ROM, a two-entry zero-flag branch ROM, or a two-entry interrupt branch ROM. The datapath is not part of the block.

The first fetch state is the only place where a pending, enabled interrupt (the `onInt` input) is tested. If no interrupt is pending, fetch goes on in the usual way: address the memory, load the instruction register, increment the PC, then dispatch on the opcode. If an interrupt is pending, a three-state entry sequence runs before fetch starts again:

1. The PC is written into register $k0.
2. The interrupt enable flag is cleared, the acknowledge strobe is raised, and the device index driven on the bus is latched as a memory address.
3. The vector word read from that address is loaded into the PC.

The opcodes for enable, disable and return-from-interrupt each have one microstate. Every other opcode goes straight back to fetch.

Top module: `irqMicroSeq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the first fetch state. A reset applied in the middle of any sequence also does this. In that state the word sets bits 9, 13 and 14 (PC onto bus, load memory address, load A) and carries next-state field 1.
- R2: With `onInt` low in the first fetch state, the following cycles give two more fetch words. The second sets bits 7 and 12 (memory onto bus, load instruction register) with field 2. The third sets bits 8 and 11, ALU select bits 22:21 = 11 (A+1), and bit 23 (opcode dispatch), with field 0.
- R3: `onInt` is sampled only in the first fetch state. When it is high there, the next state is the interrupt entry. When it is high in any other state, it has no effect.
- R4: Interrupt entry is three words, followed by the first fetch state.
  - Word one sets bits 9 and 17, with register select bits 20:19 = 11 ($k0), and field 9.
  - Word two sets bit 25 (load enable flag), leaves bit 26 (enable value) at 0, and sets bit 27 (acknowledge) and bit 13, with field 10.
  - Word three sets bits 7 and 11, with field 0.
- R5: Opcode 1010 leads to a single word with bits 25 and 26 set. Opcode 1011 leads to a single word with only bit 25 set. Opcode 1100 leads to a single word with bits 6, 11, 19, 20, 25 and 26 set. After each of these words the sequencer returns to the first fetch state.
- R6: Any other opcode makes the sequencer go from the third fetch state directly back to the first fetch state.
- R7: The `zFlag` input has no effect on any of these sequences, because no implemented microstate sets bit 24 (zero branch).
- R8: The opcode is sampled only in the third fetch state. Its value in any other state does not change the sequence.
- R9: The acknowledge bit 27 is raised only in the second entry word, two cycles after `onInt` was seen high.
- R10: No word drives more than one source onto the bus. The drive bits are 6 to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Instruction bits 31:28 from the instruction register |
| zFlag | input | 1 | Zero flag from the datapath |
| onInt | input | 1 | Interrupt pending and enabled |
| ctrlWord | output | 28 | Control word for the current microstate |

## Verification
The bench runs every one of the 16 opcodes under both `onInt` values at the fetch test and both `zFlag` levels. This separates the three dispatched instructions from the fall-through opcodes, and it separates interrupt entry from a plain fetch.

In each run `onInt` is held high through the later fetch states, and a wrong opcode is held until the dispatch cycle. Both must be ignored, which exposes sampling in the wrong state. A reset applied in the middle of interrupt entry checks that recovery goes to the first fetch state.

// File: rtl/irqMicroSeqPkg.sv
package irqMicroSeqPkg;
  localparam int WORD_W  = 28;
  localparam int STATE_W = 6;
  localparam int OP_W    = 4;
  localparam int NUM_OPS = 1 << OP_W;
  localparam int BR_ROM_DEPTH = 4;

  // control word bit positions (decoded by the datapath)
  localparam int B_NEXT   = 0;
  localparam int B_DRVREG = 6;
  localparam int B_DRVMEM = 7;
  localparam int B_DRVALU = 8;
  localparam int B_DRVPC  = 9;
  localparam int B_DRVOFF = 10;
  localparam int B_LDPC   = 11;
  localparam int B_LDIR   = 12;
  localparam int B_LDMAR  = 13;
  localparam int B_LDA    = 14;
  localparam int B_LDB    = 15;
  localparam int B_LDZ    = 16;
  localparam int B_WRREG  = 17;
  localparam int B_WRMEM  = 18;
  localparam int B_RSEL   = 19;
  localparam int B_ALUOP  = 21;
  localparam int B_OPTEST = 23;
  localparam int B_ZTEST  = 24;
  localparam int B_IELOAD = 25;
  localparam int B_IEVAL  = 26;
  localparam int B_ACK    = 27;

  localparam logic [1:0] RSEL_KREG = 2'b11;
  localparam logic [1:0] ALU_INC   = 2'b11;

  localparam logic [STATE_W-1:0] ST_FETCH0 = 6'd0;
  localparam logic [STATE_W-1:0] ST_FETCH1 = 6'd1;
  localparam logic [STATE_W-1:0] ST_FETCH2 = 6'd2;
  localparam logic [STATE_W-1:0] ST_INT0   = 6'd8;
  localparam logic [STATE_W-1:0] ST_INT1   = 6'd9;
  localparam logic [STATE_W-1:0] ST_INT2   = 6'd10;
  localparam logic [STATE_W-1:0] ST_IEON   = 6'd16;
  localparam logic [STATE_W-1:0] ST_IEOFF  = 6'd17;
  localparam logic [STATE_W-1:0] ST_IRET   = 6'd18;
  localparam logic [STATE_W-1:0] ST_ZTAKEN = 6'd24;

  localparam logic [OP_W-1:0] OP_IEON  = 4'b1010;
  localparam logic [OP_W-1:0] OP_IEOFF = 4'b1011;
  localparam logic [OP_W-1:0] OP_IRET  = 4'b1100;

  typedef enum logic [1:0] {
    SRC_FIELD,
    SRC_DISP,
    SRC_ZERO,
    SRC_IRQ
  } nsSrc_t;

  typedef struct packed {
    logic               opTest;
    logic               zTest;
    logic               intTest;
    logic [STATE_W-1:0] nextField;
  } seqStrobe_t;

  function automatic logic isIrqOp(input logic [OP_W-1:0] op);
    return (op == OP_IEON) || (op == OP_IEOFF) || (op == OP_IRET);
  endfunction

  function automatic logic [STATE_W-1:0] dispatchTarget(input int op);
    logic [OP_W-1:0] code;
    code = op[OP_W-1:0];
    case (code)
      OP_IEON:  return ST_IEON;
      OP_IEOFF: return ST_IEOFF;
      OP_IRET:  return ST_IRET;
      default:  return ST_FETCH0;
    endcase
  endfunction
endpackage

// File: rtl/irqMicroSeqRom.sv
module irqMicroSeqRom
  import irqMicroSeqPkg::*;
#(
  parameter logic [STATE_W-1:0] INT_TEST_STATE = ST_FETCH0
) (
  input  logic [STATE_W-1:0] state,
  output logic [WORD_W-1:0]  word,
  output seqStrobe_t         strobe
);
  always_comb begin
    word = '0;
    case (state)
      ST_FETCH0: begin
        word[B_NEXT +: STATE_W] = ST_FETCH1;
        word[B_DRVPC] = 1'b1;
        word[B_LDMAR] = 1'b1;
        word[B_LDA]   = 1'b1;
      end
      ST_FETCH1: begin
        word[B_NEXT +: STATE_W] = ST_FETCH2;
        word[B_DRVMEM] = 1'b1;
        word[B_LDIR]   = 1'b1;
      end
      ST_FETCH2: begin
        word[B_NEXT +: STATE_W] = ST_FETCH0;
        word[B_DRVALU]     = 1'b1;
        word[B_LDPC]       = 1'b1;
        word[B_ALUOP +: 2] = ALU_INC;
        word[B_OPTEST]     = 1'b1;
      end
      ST_INT0: begin
        word[B_NEXT +: STATE_W] = ST_INT1;
        word[B_DRVPC]     = 1'b1;
        word[B_WRREG]     = 1'b1;
        word[B_RSEL +: 2] = RSEL_KREG;
      end
      ST_INT1: begin
        word[B_NEXT +: STATE_W] = ST_INT2;
        word[B_IELOAD] = 1'b1;
        word[B_IEVAL]  = 1'b0;
        word[B_ACK]    = 1'b1;
        word[B_LDMAR]  = 1'b1;
      end
      ST_INT2: begin
        word[B_NEXT +: STATE_W] = ST_FETCH0;
        word[B_DRVMEM] = 1'b1;
        word[B_LDPC]   = 1'b1;
      end
      ST_IEON: begin
        word[B_IELOAD] = 1'b1;
        word[B_IEVAL]  = 1'b1;
      end
      ST_IEOFF: begin
        word[B_IELOAD] = 1'b1;
      end
      ST_IRET: begin
        word[B_DRVREG]    = 1'b1;
        word[B_RSEL +: 2] = RSEL_KREG;
        word[B_LDPC]      = 1'b1;
        word[B_IELOAD]    = 1'b1;
        word[B_IEVAL]     = 1'b1;
      end
      default: word = '0;
    endcase
  end

  assign strobe.opTest    = word[B_OPTEST];
  assign strobe.zTest     = word[B_ZTEST];
  assign strobe.intTest   = (state == INT_TEST_STATE);
  assign strobe.nextField = word[B_NEXT +: STATE_W];

  always_comb begin
    AST_ONE_DRIVER: assert ($onehot0(word[B_DRVOFF:B_DRVREG])); // R10
  end
endmodule

// File: rtl/irqMicroSeqNext.sv
module irqMicroSeqNext
  import irqMicroSeqPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [OP_W-1:0]    opcode,
  input  logic               zFlag,
  input  logic               onInt,
  output logic [STATE_W-1:0] state
);
  logic [STATE_W-1:0] dispRom [NUM_OPS];
  logic [STATE_W-1:0] irqRom  [BR_ROM_DEPTH];
  logic [STATE_W-1:0] zeroRom [BR_ROM_DEPTH];
  logic [STATE_W-1:0] nextState;
  nsSrc_t             nsSrc;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gDisp
    assign dispRom[g] = dispatchTarget(g);
  end

  // two-entry branch ROMs; upper address bit is tied low
  for (genvar g = 0; g < BR_ROM_DEPTH; g++) begin : gBr
    assign irqRom[g]  = (g == 0) ? ST_FETCH1 : (g == 1) ? ST_INT0 : ST_FETCH0;
    assign zeroRom[g] = (g == 1) ? ST_ZTAKEN : ST_FETCH0;
  end

  always_comb begin
    if (strobe.opTest)       nsSrc = SRC_DISP;
    else if (strobe.zTest)   nsSrc = SRC_ZERO;
    else if (strobe.intTest) nsSrc = SRC_IRQ;
    else                     nsSrc = SRC_FIELD;
  end

  always_comb begin
    case (nsSrc)
      SRC_DISP: nextState = dispRom[opcode];
      SRC_ZERO: nextState = zeroRom[{1'b0, zFlag}];
      SRC_IRQ:  nextState = irqRom[{1'b0, onInt}];
      default:  nextState = strobe.nextField;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH0;
    else     state <= nextState;
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> state == ST_FETCH0); // R1
  AST_INT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INT0) |-> ($past(state) == ST_FETCH0 && $past(onInt))); // R3
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (strobe.opTest && !isIrqOp(opcode)) |=> state == ST_FETCH0); // R6
endmodule

// File: rtl/irqMicroSeq.sv
module irqMicroSeq
  import irqMicroSeqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zFlag,
  input  logic              onInt,
  output logic [WORD_W-1:0] ctrlWord
);
  logic [STATE_W-1:0] state;
  seqStrobe_t         strobe;

  irqMicroSeqRom #(.INT_TEST_STATE(ST_FETCH0)) u_rom (
    .state  (state),
    .word   (ctrlWord),
    .strobe (strobe)
  );

  irqMicroSeqNext u_next (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opcode (opcode),
    .zFlag  (zFlag),
    .onInt  (onInt),
    .state  (state)
  );

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    ctrlWord[B_ACK] |-> $past(onInt, 2)); // R9
endmodule

// File: tb/irqMicroSeq_test.sv
`timescale 1ns/1ps
module irqMicroSeq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'd0;
  logic        zFlag = 1'b0;
  logic        onInt = 1'b0;
  logic [27:0] ctrlWord;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  irqMicroSeq uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .zFlag(zFlag), .onInt(onInt), .ctrlWord(ctrlWord)
  );

  always #2.5 clk = ~clk;

  function automatic logic [27:0] bitv(input int b);
    return 28'd1 << b;
  endfunction

  // expected words built from the bit positions in the requirements
  logic [27:0] wF0, wF1, wF2, wI0, wI1, wI2, wEon, wEoff, wRet;
  initial begin
    wF0   = 28'd1 | bitv(9) | bitv(13) | bitv(14);
    wF1   = 28'd2 | bitv(7) | bitv(12);
    wF2   = bitv(8) | bitv(11) | bitv(21) | bitv(22) | bitv(23);
    wI0   = 28'd9 | bitv(9) | bitv(17) | bitv(19) | bitv(20);
    wI1   = 28'd10 | bitv(25) | bitv(27) | bitv(13);
    wI2   = bitv(7) | bitv(11);
    wEon  = bitv(25) | bitv(26);
    wEoff = bitv(25);
    wRet  = bitv(6) | bitv(19) | bitv(20) | bitv(11) | bitv(25) | bitv(26);
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [27:0] exp, input string req);
    vectors++;
    if (ctrlWord !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, ctrlWord, exp);
    end
  endtask

  task automatic runOne(input logic [3:0] op, input logic irq, input logic zv);
    chk(wF0, "R1/R2 first fetch word");
    onInt  = irq;
    zFlag  = zv;                 // R7: must not matter
    opcode = op ^ 4'b0101;       // R8: wrong opcode until dispatch
    step();
    if (irq) begin
      chk(wI0, "R4 entry word 1");
      onInt = 1'b0;
      step();
      chk(wI1, "R4/R9 entry word 2");
      step();
      chk(wI2, "R4 entry word 3");
      step();
      chk(wF0, "R4 return to fetch");
      step();
    end
    chk(wF1, "R2/R3 second fetch word");
    onInt  = 1'b1;               // R3: ignored outside first fetch state
    opcode = op;
    step();
    chk(wF2, "R2/R3 third fetch word");
    step();
    case (op)
      4'b1010: begin chk(wEon, "R5 enable word");  onInt = 1'b0; step(); end
      4'b1011: begin chk(wEoff, "R5 disable word"); onInt = 1'b0; step(); end
      4'b1100: begin chk(wRet, "R5 return word");  onInt = 1'b0; step(); end
      default: chk(wF0, "R6 fall-through to fetch");
    endcase
    onInt = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    step();
    step();
    chk(wF0, "R1 word during reset");
    rst = 1'b0;
    chk(wF0, "R1 reset state");
    for (int op = 0; op < 16; op++) begin
      for (int irq = 0; irq < 2; irq++) begin
        for (int zv = 0; zv < 2; zv++) begin
          runOne(op[3:0], irq[0], zv[0]);
        end
      end
    end
    // R1: reset in the middle of interrupt entry
    chk(wF0, "R1 before mid-run reset");
    onInt = 1'b1;
    step();
    chk(wI0, "R3 entry taken");
    onInt = 1'b0;
    step();
    chk(wI1, "R4 entry word 2");
    rst = 1'b1;
    step();
    chk(wF0, "R1 mid-run reset");
    rst = 1'b0;
    step();
    chk(wF1, "R1 fetch resumes");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule